// File: doc/BRIEF.md
# Source-Synchronous Pixel Serializer

This block turns one parallel video word per pixel period into a fixed 30-bit frame and shifts that frame out over one or more serial data lanes. The word holds 24 bits of colour (8 per channel), the three timing flags (horizontal sync, vertical sync, data enable) and two spare general-purpose bits. The block appends one even-parity bit. No line coding is applied. A forwarded clock and a frame-start marker travel beside the data lanes, so a receiver can align to each frame.

The bit clock is a synchronous enable, `bit_en_i`, on the block clock. One bit slot passes on every cycle where it is high. A pixel word is captured into a holding register on any cycle with `pix_en_i` high. The lane shift registers reload from the holding register at the first slot of every frame. The lane count is set at elaboration. With NUM_LANES lanes, each frame takes ceil(30/NUM_LANES) bit slots, so the per-lane rate drops by that factor.

Top module: `pix_serializer`

## Requirements
- R1: Frame bit k (k = 0 first) is taken from the sequence red[7:0], green[7:0], blue[7:0], hsync, vsync, de, gp[1:0], parity, most significant bit of each field first. With one lane the frame is sent on lane 0 over 30 consecutive bit slots.
- R2: The parity bit (frame bit 29) makes the number of ones in the 30-bit frame even.
- R3: With N lanes, frame bit k is sent on lane k mod N in slot k div N. A frame lasts S = ceil(30/N) slots, and slots that are not filled by a frame bit carry 0.
- R4: `frame_o` is high during slot 0 of each frame and low in every other slot. When `bit_en_i` is held high, it recurs every S bit slots.
- R5: `fwd_clk_o` is high during slots 0 to S/2-1 of each frame (integer division, at least one slot) and low otherwise.
- R6: A word presented with `pix_en_i` high is captured at that clock edge and sent in the next frame that starts at a later edge. If the capture and a frame start fall on the same edge, that frame carries the previously held word.
- R7: While `bit_en_i` is low, `lane_o`, `frame_o` and `fwd_clk_o` hold their values.
- R8: While `rst_ni` is low, `lane_o` is all zero and `frame_o` and `fwd_clk_o` are low, without waiting for a clock edge. They stay so until the first `bit_en_i` after reset, which starts a frame built from an all-zero held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Capture the pixel word this cycle |
| bit_en_i | input | 1 | One serial bit slot passes this cycle |
| red_i | input | 8 | Red channel |
| grn_i | input | 8 | Green channel |
| blu_i | input | 8 | Blue channel |
| hsync_i | input | 1 | Horizontal sync flag |
| vsync_i | input | 1 | Vertical sync flag |
| de_i | input | 1 | Data enable flag |
| gp_i | input | 2 | General-purpose spare bits |
| lane_o | output | NUM_LANES | Serial data, one bit per lane |
| frame_o | output | 1 | Frame-start marker (slot 0) |
| fwd_clk_o | output | 1 | Forwarded pixel-rate clock |

## Verification
The hardest case to reach from the ports is a capture that lands on the same edge as a frame reload, because the outcome turns on one register stage. The bench locks onto the frame marker, counts bit slots up to the last slot of the frame, and only then presents a new word with `pix_en_i`. It then expects the old word in the frame that begins at that edge and the new word in the frame after it. Stalls of the bit enable and a reset applied mid-frame are placed at known slot positions in the same way.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;

  localparam int FRAME_W = 30;

  typedef struct packed {
    logic [7:0] red;
    logic [7:0] grn;
    logic [7:0] blu;
    logic       hsync;
    logic       vsync;
    logic       de;
    logic [1:0] gp;
  } pix_word_t;

  localparam int WORD_W = $bits(pix_word_t);

  // MSB of result is the first bit on the wire; parity last
  function automatic logic [FRAME_W-1:0] build_frame(pix_word_t w);
    return {w, ^w};
  endfunction

endpackage

// File: rtl/pix_frame_hold.sv
module pix_frame_hold
  import pix_ser_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  pix_word_t          word_i,
  output logic [FRAME_W-1:0] frame_o
);

  pix_word_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (cap_i) hold_q <= word_i;
  end

  assign frame_o = build_frame(hold_q);

endmodule

// File: rtl/pix_slot_timer.sv
module pix_slot_timer #(
  parameter int SLOTS = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  output logic load_o,
  output logic shift_o,
  output logic frame_o,
  output logic fwd_clk_o
);

  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int HALF   = (SLOTS > 1) ? SLOTS / 2 : 1;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] HI_N = SLOT_W'(HALF);

  logic [SLOT_W-1:0] slot_q;
  logic              run_q;
  logic              wrap;

  assign wrap    = (slot_q == LAST);
  assign load_o  = bit_en_i & wrap;
  assign shift_o = bit_en_i & ~wrap;

  // slot_q parks on LAST so the first enable after reset starts a frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= LAST;
      run_q  <= 1'b0;
    end else if (bit_en_i) begin
      slot_q <= wrap ? '0 : slot_q + 1'b1;
      run_q  <= 1'b1;
    end
  end

  assign frame_o   = run_q & (slot_q == '0);
  assign fwd_clk_o = run_q & ((HALF >= SLOTS) | (slot_q < HI_N));

endmodule

// File: rtl/pix_lane_shifter.sv
module pix_lane_shifter
  import pix_ser_pkg::*;
#(
  parameter int NUM_LANES = 1,
  parameter int LANE      = 0,
  parameter int SLOTS     = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               bit_o
);

  logic [SLOTS-1:0] pat;
  logic [SLOTS-1:0] sr_q;

  // round-robin deal: frame bit k -> lane k%N, slot k/N; pads are 0
  always_comb begin
    pat = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (s * NUM_LANES + LANE < FRAME_W)
        pat[SLOTS-1-s] = frame_i[FRAME_W-1-(s*NUM_LANES+LANE)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= pat;
    else if (shift_i) sr_q <= sr_q << 1;
  end

  assign bit_o = sr_q[SLOTS-1];

endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pix_ser_pkg::*;
#(
  parameter int NUM_LANES = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pix_en_i,
  input  logic                 bit_en_i,
  input  logic [7:0]           red_i,
  input  logic [7:0]           grn_i,
  input  logic [7:0]           blu_i,
  input  logic                 hsync_i,
  input  logic                 vsync_i,
  input  logic                 de_i,
  input  logic [1:0]           gp_i,
  output logic [NUM_LANES-1:0] lane_o,
  output logic                 frame_o,
  output logic                 fwd_clk_o
);

  localparam int SLOTS = (FRAME_W + NUM_LANES - 1) / NUM_LANES;

  pix_word_t          word;
  logic [FRAME_W-1:0] frame_w;
  logic               load, shift;

  assign word = '{red: red_i, grn: grn_i, blu: blu_i, hsync: hsync_i,
                  vsync: vsync_i, de: de_i, gp: gp_i};

  pix_frame_hold i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (pix_en_i),
    .word_i (word),
    .frame_o(frame_w)
  );

  pix_slot_timer #(.SLOTS(SLOTS)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .load_o   (load),
    .shift_o  (shift),
    .frame_o  (frame_o),
    .fwd_clk_o(fwd_clk_o)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    pix_lane_shifter #(.NUM_LANES(NUM_LANES), .LANE(l), .SLOTS(SLOTS)) i_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .shift_i(shift),
      .frame_i(frame_w),
      .bit_o  (lane_o[l])
    );
  end

endmodule

// File: rtl/pix_serializer_chk.sv
module pix_serializer_chk
  import pix_ser_pkg::*;
#(
  parameter int NUM_LANES = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bit_en_i,
  input logic [NUM_LANES-1:0] lane_o,
  input logic                 frame_o,
  input logic                 fwd_clk_o,
  input logic [FRAME_W-1:0]   frame_w
);

  localparam int SLOTS = (FRAME_W + NUM_LANES - 1) / NUM_LANES;

  // R2: held frame always has even weight
  a_r2_even_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(frame_w) % 2 == 0);

  // R7: stalled bit clock freezes the link
  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(lane_o) && $stable(frame_o) && $stable(fwd_clk_o)));

  // R5: forwarded clock is high in the marker slot
  a_r5_fwd_high_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> fwd_clk_o);

  // R4: marker lasts one slot
  if (SLOTS > 1) begin : g_multi
    a_r4_marker_one_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_o && bit_en_i) |=> !frame_o);
  end

  // R8: quiet outputs in reset
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_quiet: assert (lane_o == '0 && !frame_o && !fwd_clk_o);
    end
  end

endmodule

bind pix_serializer pix_serializer_chk #(.NUM_LANES(NUM_LANES)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_en_i (bit_en_i),
  .lane_o   (lane_o),
  .frame_o  (frame_o),
  .fwd_clk_o(fwd_clk_o),
  .frame_w  (frame_w)
);

// File: tb/test_pix_serializer.sv
module test_pix_serializer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0, bit_en = 1'b0;
  logic [7:0] red = '0, grn = '0, blu = '0;
  logic       hs = 1'b0, vs = 1'b0, de = 1'b0;
  logic [1:0] gp = '0;
  logic [0:0] lane1;
  logic [3:0] lane4;
  logic       mk1, mk4, fc1, fc4;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pix_serializer #(.NUM_LANES(1)) i_pix_serializer (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .bit_en_i(bit_en),
    .red_i(red), .grn_i(grn), .blu_i(blu), .hsync_i(hs), .vsync_i(vs),
    .de_i(de), .gp_i(gp), .lane_o(lane1), .frame_o(mk1), .fwd_clk_o(fc1));

  pix_serializer #(.NUM_LANES(4)) i_pix_serializer_q (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .bit_en_i(bit_en),
    .red_i(red), .grn_i(grn), .blu_i(blu), .hsync_i(hs), .vsync_i(vs),
    .de_i(de), .gp_i(gp), .lane_o(lane4), .frame_o(mk4), .fwd_clk_o(fc4));

  // bits 29:1 = inputs (red..gp), bit 0 = expected even parity
  localparam logic [29:0] VEC [6] = '{
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0},
    {8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1},
    {8'hA5, 8'h3C, 8'h0F, 1'b0, 1'b1, 1'b1, 2'b10, 1'b1},
    {8'h80, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0},
    {8'h12, 8'h34, 8'h56, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0},
    {8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [29:0] v, input logic pe);
    {red, grn, blu, hs, vs, de, gp} = v[29:1];
    pix_en = pe;
  endtask

  // collect one frame from DUT q (0: one lane, 1: four lanes)
  task automatic grab(input int q, input logic [29:0] f, input bit skip, input string rd);
    int n     = q ? 4 : 1;
    int slots = q ? 8 : 30;
    int guard = 0;
    logic [63:0] got = '0, exp = '0;
    logic [31:0] mk_got = '0, mk_exp = '0, fc_got = '0, fc_exp = '0;
    if (skip) @(negedge clk);
    while (!(q ? mk4 : mk1) && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    for (int s = 0; s < slots; s++) begin
      if (s > 0) @(negedge clk);
      for (int l = 0; l < n; l++) begin
        int k = s * n + l;
        got = {got[62:0], (q ? lane4[l] : lane1[0])};
        exp = {exp[62:0], (k < 30) ? f[29-k] : 1'b0};
      end
      mk_got[s] = q ? mk4 : mk1;
      mk_exp[s] = (s == 0);
      fc_got[s] = q ? fc4 : fc1;
      fc_exp[s] = (s < slots / 2);
    end
    @(negedge clk);
    mk_got[slots] = q ? mk4 : mk1;
    mk_exp[slots] = 1'b1;
    chk(got == exp, rd, q ? "quad-lane frame" : "single-lane frame", got, exp);
    chk(mk_got == mk_exp, "R4", "marker pattern", 64'(mk_got), 64'(mk_exp));
    chk(fc_got == fc_exp, "R5", "forwarded clock pattern", 64'(fc_got), 64'(fc_exp));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [29:0] w_old, w_new;
    logic [3:0]  snap_l;
    logic        snap_m, snap_f;

    // R8: reset quiet, then stay quiet until the first bit enable
    repeat (3) @(negedge clk);
    chk(lane1 == 0 && lane4 == 0 && !mk1 && !mk4 && !fc1 && !fc4, "R8", "in reset",
        {lane4, lane1, mk1, mk4, fc1, fc4}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(lane1 == 0 && lane4 == 0 && !mk1 && !mk4 && !fc1 && !fc4, "R8", "idle after reset",
        {lane4, lane1, mk1, mk4, fc1, fc4}, '0);
    bit_en = 1'b1;
    grab(0, 30'h0, 1'b0, "R8");

    // table walk: R1 on one lane, R3 on four lanes, R2 on parity bit
    foreach (VEC[i]) begin
      drive(VEC[i], 1'b1);
      @(negedge clk);
      pix_en = 1'b0;
      grab(0, VEC[i], 1'b1, "R1");
      grab(1, VEC[i], 1'b0, "R3");
      chk(VEC[i][0] == ^VEC[i][29:1], "R2", "table parity even", 64'(VEC[i][0]),
          64'(^VEC[i][29:1]));
    end

    // R6: capture on the same edge as a reload keeps the old word
    w_old = VEC[3];
    w_new = VEC[2];
    drive(w_old, 1'b1);
    @(negedge clk);
    pix_en = 1'b0;
    while (!mk1) @(negedge clk);
    repeat (29) @(negedge clk);
    drive(w_new, 1'b1);
    @(negedge clk);
    pix_en = 1'b0;
    grab(0, w_old, 1'b0, "R6");
    grab(0, w_new, 1'b0, "R6");

    // R7: stall mid-frame
    repeat (7) @(negedge clk);
    bit_en = 1'b0;
    @(negedge clk);
    snap_l = lane4; snap_m = mk1; snap_f = fc4;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(lane4 == snap_l && mk1 == snap_m && fc4 == snap_f, "R7", "held during stall",
          {lane4, mk1, fc4}, {snap_l, snap_m, snap_f});
    end
    bit_en = 1'b1;
    grab(1, w_new, 1'b0, "R7");

    // R8: asynchronous reset in the middle of a frame
    while (!mk1) @(negedge clk);
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk(lane1 == 0 && lane4 == 0 && !mk1 && !mk4 && !fc1 && !fc4, "R8", "async clear",
        {lane4, lane1, mk1, mk4, fc1, fc4}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    grab(1, 30'h0, 1'b0, "R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule